// File: doc/BRIEF.md
# Peak Detector Hold and Reset Controller

This block drives the shared control lines of five external analog peak detectors. Each detector tracks the largest positive input on its channel. The detectors hand this block two digital flags per channel: one says the channel rose above its discriminator threshold, and one marks a negative-going zero crossing. When a crossing arrives on a channel that first passed its threshold, the block opens a short request window. The window lasts a fixed time of about 2 µs and is counted in clock cycles.

If a start pulse arrives while the window is open, the block raises a common hold line. Hold keeps every detector's peak for the whole analog-to-digital conversion. When the sequencer reports that the conversion is done, hold drops and a reset pulse clears all detectors. If the window runs out with no start pulse, the same reset pulse is issued. The block works only while a converter is powered and the particle-telescope mode is selected. Outside that state, every output is low and all internal state is cleared.

Top module: `pkdet_hold_ctl`

## Requirements
- R1: After rst_n is released, hold, det_reset and req_win are all low, and no channel is armed.
- R2: A zero crossing on an armed channel, seen when hold, window and reset are all idle, raises req_win at the next clock edge. req_win then stays high for exactly WIN_CYC cycles, where WIN_CYC = CLK_HZ/1000 * WIN_NS / 1000000 (500 at the defaults).
- R3: A start pulse seen while req_win is high sets hold at the next edge and drops req_win at that same edge. Hold then stays high until conv_done.
- R4: thr_hit[i] arms channel i. A zero crossing on a channel that is not armed opens no window.
- R5: If the window ends with no start, det_reset rises at the edge where req_win falls and stays high for RST_MIN cycles. The reset disarms every channel, and any thr_hit seen while det_reset is high is discarded.
- R6: conv_done seen while hold is high drops hold at the next edge and starts the same RST_MIN-cycle det_reset pulse, with the same disarming.
- R7: While hold or det_reset is high, zero crossings start no window.
- R8: A start pulse outside the window does not set hold. conv_done while hold is low does not produce a reset.
- R9: While conv_pwr or tele_mode is low, all three outputs are low in the same cycle and all state is cleared. Channels that were armed before must therefore be armed again.
- R10: Any one of the NCH channels can open the window, and the resulting reset is common to all detectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_pwr | input | 1 | A converter is powered |
| tele_mode | input | 1 | Particle-telescope mode selected |
| thr_hit | input | NCH | Per-channel threshold-exceeded flags |
| zc_neg | input | NCH | Per-channel negative zero-crossing flags |
| start | input | 1 | Start (read request) pulse |
| conv_done | input | 1 | Conversion finished, from the sequencer |
| hold | output | 1 | Common peak hold |
| det_reset | output | 1 | Common detector reset pulse |
| req_win | output | 1 | Request window open |

## Verification
The bench measures the window length in cycles. A counter that is off by one gives 499 or 501 cycles instead of 500. It also checks that det_reset starts in the same cycle the window closes, and a design with an extra register stage would show a one-cycle gap. Zero crossings are driven on unarmed channels, during hold and right after a reset, where a design that forgot to gate them would open a second window or release hold early. The power and mode enables are dropped in the middle of a window and in the middle of a hold. A design that only gated its outputs would then reopen with stale armed flags once the enables return.

// File: rtl/pkdet_hold_ctl.sv
module pkdet_hold_ctl #(
  parameter int NCH     = 5,
  parameter int CLK_HZ  = 250_000_000,
  parameter int WIN_NS  = 2000,
  parameter int RST_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_pwr,
  input  logic           tele_mode,
  input  logic [NCH-1:0] thr_hit,
  input  logic [NCH-1:0] zc_neg,
  input  logic           start,
  input  logic           conv_done,
  output logic           hold,
  output logic           det_reset,
  output logic           req_win
);
  localparam int WIN_CYC = (CLK_HZ / 1000) * WIN_NS / 1_000_000;
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int RW = $clog2(RST_MIN + 1);

  logic           en, hold_q, fire, open;
  logic [NCH-1:0] armed;
  logic [WW-1:0]  win_q;
  logic [RW-1:0]  rst_q;

  assign en   = conv_pwr & tele_mode;
  assign fire = (hold_q & conv_done) | (win_q != '0 && !start && win_q == WW'(1));
  assign open = !hold_q && win_q == '0 && rst_q == '0 && |(zc_neg & armed);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      hold_q <= 1'b0;
      win_q  <= '0;
      rst_q  <= '0;
      armed  <= '0;
    end else begin
      if (hold_q) begin
        if (conv_done) hold_q <= 1'b0;
      end else if (win_q != '0) begin
        if (start) begin
          hold_q <= 1'b1;
          win_q  <= '0;
        end else begin
          win_q <= win_q - WW'(1);
        end
      end else if (open) begin
        win_q <= WW'(WIN_CYC);
      end

      if (fire)            rst_q <= RW'(RST_MIN);
      else if (rst_q != '0) rst_q <= rst_q - RW'(1);

      if (fire || rst_q != '0) armed <= '0;
      else                     armed <= armed | thr_hit;
    end
  end

  assign hold      = en & hold_q;
  assign det_reset = en & (rst_q != '0);
  assign req_win   = en & (win_q != '0);

  a_r2_win_not_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_win |-> !hold);
  a_r3_hold_from_win: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(req_win && start));
  a_r3_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !conv_done && en) |=> hold || !en);
  a_r6_done_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && conv_done && en) |=> (!hold && (det_reset || !en)));
  a_r5_rst_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_reset) |-> $past(req_win || hold));
  a_r7_no_win_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (det_reset && en) |=> !$rose(req_win));
endmodule

// File: tb/sim_pkdet_hold_ctl.sv
module sim_pkdet_hold_ctl;
  localparam int NCH = 5, RST = 3, WIN = 500;

  logic clk = 1'b0, rst_n = 1'b0, conv_pwr = 1'b0, tele_mode = 1'b0;
  logic [NCH-1:0] thr_hit = '0, zc_neg = '0;
  logic start = 1'b0, conv_done = 1'b0;
  logic hold, det_reset, req_win;

  pkdet_hold_ctl #(.NCH(NCH), .CLK_HZ(250_000_000), .WIN_NS(2000), .RST_MIN(RST)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_pwr(conv_pwr), .tele_mode(tele_mode),
    .thr_hit(thr_hit), .zc_neg(zc_neg), .start(start), .conv_done(conv_done),
    .hold(hold), .det_reset(det_reset), .req_win(req_win));

  always #2ns clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_hold = 0, m_win = 0, m_rst = 0;
  bit m_arm[NCH];

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    bit en, fire, hit, was_rst;
    cyc++;
    en = conv_pwr && tele_mode;
    if (!rst_n || !en) begin
      m_hold = 0; m_win = 0; m_rst = 0;
      foreach (m_arm[i]) m_arm[i] = 0;
    end else begin
      fire = 0; hit = 0; was_rst = m_rst > 0;
      foreach (m_arm[i]) if (m_arm[i] && zc_neg[i]) hit = 1;
      if (m_hold != 0) begin
        if (conv_done) begin m_hold = 0; fire = 1; end
      end else if (m_win > 0) begin
        if (start) begin m_hold = 1; m_win = 0; end
        else if (m_win == 1) begin m_win = 0; fire = 1; end
        else m_win--;
      end else if (!was_rst && hit) m_win = WIN;
      foreach (m_arm[i]) m_arm[i] = (fire || was_rst) ? 1'b0 : (m_arm[i] | thr_hit[i]);
      if (fire) m_rst = RST; else if (m_rst > 0) m_rst--;
    end
  end

  always @(negedge clk) begin
    bit en;
    en = conv_pwr && tele_mode;
    if (rst_n) begin
      chk("R3 hold model", hold, en && m_hold != 0);
      chk("R5 det_reset model", det_reset, en && m_rst > 0);
      chk("R2 req_win model", req_win, en && m_win > 0);
    end
    if (cyc > 200000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_zc(int ch); zc_neg[ch] = 1'b1; tick(1); zc_neg = '0; endtask
  task automatic pulse_thr(int ch); thr_hit[ch] = 1'b1; tick(1); thr_hit = '0; endtask
  task automatic pulse_start(); start = 1'b1; tick(1); start = 1'b0; endtask
  task automatic pulse_done(); conv_done = 1'b1; tick(1); conv_done = 1'b0; endtask

  initial begin
    int cnt;
    tick(3);
    rst_n = 1'b1; conv_pwr = 1'b1; tele_mode = 1'b1;
    tick(1);
    chk("R1 hold after reset", hold, 1'b0);
    chk("R1 det_reset after reset", det_reset, 1'b0);
    chk("R1 req_win after reset", req_win, 1'b0);

    pulse_zc(2); tick(2);
    chk("R4 unarmed crossing ignored", req_win, 1'b0);

    pulse_thr(2); tick(2);
    zc_neg[2] = 1'b1; tick(1); zc_neg = '0;
    cnt = 0;
    while (req_win) begin cnt++; tick(1); end
    chk("R2 window length", cnt == WIN, 1'b1);
    cnt = 0;
    while (det_reset) begin cnt++; tick(1); end
    chk("R5 reset follows window expiry", cnt == RST, 1'b1);
    pulse_zc(2); tick(2);
    chk("R5 reset disarms channel", req_win, 1'b0);

    pulse_thr(0); pulse_thr(4); tick(1);
    pulse_zc(4);
    chk("R10 any channel opens window", req_win, 1'b1);
    tick(100);
    pulse_start();
    chk("R3 start sets hold", hold, 1'b1);
    chk("R3 window closes on hold", req_win, 1'b0);
    pulse_zc(0); tick(5);
    chk("R7 crossing ignored in hold", req_win, 1'b0);
    pulse_start(); tick(200);
    chk("R3 hold kept until done", hold, 1'b1);
    pulse_done();
    chk("R6 done drops hold", hold, 1'b0);
    chk("R6 done fires reset", det_reset, 1'b1);
    pulse_thr(1);
    pulse_zc(1);
    chk("R7 crossing ignored in reset", req_win, 1'b0);
    tick(RST + 2);
    pulse_zc(1); tick(1);
    chk("R5 thr during reset discarded", req_win, 1'b0);

    pulse_start(); tick(2);
    chk("R8 start outside window ignored", hold, 1'b0);
    pulse_done(); tick(1);
    chk("R8 done without hold ignored", det_reset, 1'b0);

    pulse_thr(3); pulse_zc(3); tick(10);
    tele_mode = 1'b0; #1ns;
    chk("R9 mode off clears window", req_win, 1'b0);
    tick(3); tele_mode = 1'b1; tick(2);
    chk("R9 window gone after re-enable", req_win, 1'b0);
    pulse_zc(3); tick(1);
    chk("R9 armed flags cleared", req_win, 1'b0);
    pulse_thr(3); pulse_zc(3); tick(4); pulse_start(); tick(20);
    conv_pwr = 1'b0; #1ns;
    chk("R9 power off drops hold", hold, 1'b0);
    tick(2); conv_pwr = 1'b1; tick(3);
    chk("R9 hold stays low after re-enable", hold, 1'b0);
    chk("R9 no reset after re-enable", det_reset, 1'b0);
    tick(5);
    finish_up();
  end
endmodule